// File: doc/BRIEF.md
# SDI Bit-Rate Detector

This block decides whether a recovered serial-video receive clock runs at the integer bit rate (1000/1000) or at the fractional rate (1000/1001). It measures the recovered clock against a fixed-frequency reference clock. Over a fixed window of reference cycles, a counter in the recovered domain counts edges. At the end of each window that count is handed to the reference domain through a toggle handshake. The reference side classifies each window from the roughly 0.1% gap between the two expected counts. It also flags drift when the count strays too far from the expected value for its class.

The classification of a single window never reaches the outputs directly. A run of consecutive windows that agree on both class and drift must come first. Only then does the block commit the rate flag and the drift flag. It pulses a one-cycle change strobe whenever the committed rate flips. Software or a reprogramming controller elsewhere uses the rate flag and the strobe. The nominal integer-rate count and the drift threshold are inputs, so one instance serves any line rate.

Top module: `sdi_rate_detect`

## Requirements
- R1: While rst_ni is low, and after release until the first committed decision, rate_frac_o, drift_o and rate_chg_o are 0.
- R2: A measurement window lasts 2^WIN_LOG2 reference cycles. At each window end the recovered-clock edge count of the elapsed window is captured and the recovered counter restarts, so no edge is lost or counted twice.
- R3: A window is classified fractional when its count is below nominal_cnt_i - (nominal_cnt_i >> 11). Otherwise it is integer.
- R4: A window shows drift when the absolute difference between its count and the expected count exceeds drift_thr_i. The expected count is nominal_cnt_i for an integer window and nominal_cnt_i - (nominal_cnt_i >> 10) for a fractional one.
- R5: rate_frac_o and drift_o change only after VALID_N consecutive windows agree on both class and drift. A disagreeing window restarts the run, so a shorter excursion leaves the outputs unchanged.
- R6: rate_chg_o is high for exactly one reference cycle each time rate_frac_o changes value, and never otherwise.
- R7: The captured count crosses into the reference domain by a toggle request/acknowledge pair. The captured value changes only together with an acknowledge toggle, and the reference side samples it only after the acknowledge has passed SYNC_N flops.
- R8: A change of drift status with no change of class updates drift_o without a rate_chg_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Fixed-frequency reference clock |
| rec_clk_i | input | 1 | Recovered receive clock under measurement |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| nominal_cnt_i | input | CNT_W | Expected recovered count per window at the integer rate |
| drift_thr_i | input | CNT_W | Largest tolerated count deviation before drift is flagged |
| rate_frac_o | output | 1 | Committed rate: 1 fractional, 0 integer |
| rate_chg_o | output | 1 | One-cycle strobe when the committed rate flips |
| drift_o | output | 1 | Committed drift status |

## Verification
The recovered clock is run at an exact integer period and at a period 0.1% longer. These two runs separate the classes across the narrow midpoint. Two further periods, one slower than fractional and one faster than integer, fall on each side of the class boundary but outside the drift threshold. They show that drift is judged against the expected count of each class, and that a drift-only change raises no strobe. A fractional excursion lasting one and a half windows, and a check taken two windows after a real switch, show that fewer agreeing windows than the validation count leave the outputs untouched.

// File: rtl/srd_pkg.sv
`timescale 1ns/1ps
package srd_pkg;
  typedef struct packed {
    logic frac;
    logic drift;
  } srd_obs_t;
endpackage

// File: rtl/srd_rec_count.sv
`timescale 1ns/1ps
// Recovered-clock domain: edge counter, capture on request toggle.
module srd_rec_count #(
  parameter int CNT_W  = 20,
  parameter int SYNC_N = 2
) (
  input  logic             rec_clk_i,
  input  logic             rst_ni,
  input  logic             req_tgl_i,
  output logic [CNT_W-1:0] hold_o,
  output logic             ack_tgl_o
);
  logic [SYNC_N-1:0] req_sync_q;
  logic              req_seen_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  hold_q;
  logic              ack_q;
  logic              req_evt;

  assign req_evt = req_sync_q[SYNC_N-1] ^ req_seen_q;

  always_ff @(posedge rec_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_sync_q <= '0;
      req_seen_q <= 1'b0;
      cnt_q      <= '0;
      hold_q     <= '0;
      ack_q      <= 1'b0;
    end else begin
      req_sync_q <= {req_sync_q[SYNC_N-2:0], req_tgl_i};
      if (req_evt) begin
        req_seen_q <= req_sync_q[SYNC_N-1];
        hold_q     <= cnt_q;
        cnt_q      <= {{(CNT_W-1){1'b0}}, 1'b1}; // capture edge opens next window
        ack_q      <= ~ack_q;
      end else if (cnt_q != '1) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign hold_o    = hold_q;
  assign ack_tgl_o = ack_q;

  a_r7_hold_with_ack: assert property (@(posedge rec_clk_i) disable iff (!rst_ni)
    !$stable(hold_q) |-> !$stable(ack_q));
  a_r2_count_restart: assert property (@(posedge rec_clk_i) disable iff (!rst_ni)
    !$stable(ack_q) |-> (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1}));
endmodule

// File: rtl/srd_window.sv
`timescale 1ns/1ps
// Reference domain: window timer, request issue, count intake.
module srd_window #(
  parameter int WIN_LOG2 = 16,
  parameter int CNT_W    = 20,
  parameter int SYNC_N   = 2
) (
  input  logic             ref_clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] hold_i,
  input  logic             ack_tgl_i,
  output logic             req_tgl_o,
  output logic             meas_vld_o,
  output logic [CNT_W-1:0] meas_cnt_o
);
  logic [WIN_LOG2-1:0] win_q;
  logic                req_q;
  logic                pend_q;
  logic [SYNC_N-1:0]   ack_sync_q;
  logic                ack_seen_q;
  logic                vld_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                ack_evt;
  logic                win_end;

  assign ack_evt = ack_sync_q[SYNC_N-1] ^ ack_seen_q;
  assign win_end = (win_q == '1);

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q      <= '0;
      req_q      <= 1'b0;
      pend_q     <= 1'b0;
      ack_sync_q <= '0;
      ack_seen_q <= 1'b0;
      vld_q      <= 1'b0;
      cnt_q      <= '0;
    end else begin
      win_q      <= win_q + 1'b1;
      ack_sync_q <= {ack_sync_q[SYNC_N-2:0], ack_tgl_i};
      vld_q      <= 1'b0;
      if (ack_evt) begin
        ack_seen_q <= ack_sync_q[SYNC_N-1];
        cnt_q      <= hold_i; // stable: changed with the ack, SYNC_N cycles ago
        vld_q      <= 1'b1;
      end
      if (win_end && !pend_q) begin
        req_q  <= ~req_q;
        pend_q <= 1'b1;
      end else if (ack_evt) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign req_tgl_o  = req_q;
  assign meas_vld_o = vld_q;
  assign meas_cnt_o = cnt_q;

  a_r2_req_at_window_end: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    !$stable(req_q) |-> $past(win_q) == '1);
  a_r7_ack_only_pending: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    ack_evt |-> pend_q);
  a_r2_meas_single: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    vld_q |=> !vld_q);
endmodule

// File: rtl/srd_classify.sv
`timescale 1ns/1ps
// Per-window class and drift decision.
module srd_classify
  import srd_pkg::*;
#(
  parameter int CNT_W      = 20,
  parameter int MID_SHIFT  = 11,
  parameter int FRAC_SHIFT = 10
) (
  input  logic             ref_clk_i,
  input  logic             rst_ni,
  input  logic             meas_vld_i,
  input  logic [CNT_W-1:0] meas_cnt_i,
  input  logic [CNT_W-1:0] nominal_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic             obs_vld_o,
  output srd_obs_t         obs_o
);
  logic [CNT_W-1:0] mid_cnt, frac_cnt, exp_cnt, dev_cnt;
  srd_obs_t         obs_d, obs_q;
  logic             vld_q;

  always_comb begin
    mid_cnt     = nominal_i - (nominal_i >> MID_SHIFT);
    frac_cnt    = nominal_i - (nominal_i >> FRAC_SHIFT);
    obs_d.frac  = (meas_cnt_i < mid_cnt);
    exp_cnt     = obs_d.frac ? frac_cnt : nominal_i;
    dev_cnt     = (meas_cnt_i > exp_cnt) ? (meas_cnt_i - exp_cnt) : (exp_cnt - meas_cnt_i);
    obs_d.drift = (dev_cnt > thr_i);
  end

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      obs_q <= '0;
    end else begin
      vld_q <= meas_vld_i;
      if (meas_vld_i) obs_q <= obs_d;
    end
  end

  assign obs_vld_o = vld_q;
  assign obs_o     = obs_q;

  a_r3_obs_held: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    !vld_q && !$past(meas_vld_i) |-> $stable(obs_q));
endmodule

// File: rtl/srd_validate.sv
`timescale 1ns/1ps
// Agreement run and committed outputs.
module srd_validate
  import srd_pkg::*;
#(
  parameter int VALID_N = 4
) (
  input  logic     ref_clk_i,
  input  logic     rst_ni,
  input  logic     obs_vld_i,
  input  srd_obs_t obs_i,
  output logic     rate_frac_o,
  output logic     drift_o,
  output logic     rate_chg_o
);
  localparam int AGR_W = $clog2(VALID_N + 1);
  localparam logic [AGR_W-1:0] AGR_MAX = AGR_W'(VALID_N);
  localparam logic [AGR_W-1:0] AGR_ONE = AGR_W'(1);

  logic [AGR_W-1:0] agr_q, agr_d;
  srd_obs_t         last_q;
  logic             rate_q, drift_q, chg_q;

  always_comb begin
    if (agr_q != '0 && obs_i == last_q)
      agr_d = (agr_q < AGR_MAX) ? agr_q + 1'b1 : agr_q;
    else
      agr_d = AGR_ONE;
  end

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      agr_q   <= '0;
      last_q  <= '0;
      rate_q  <= 1'b0;
      drift_q <= 1'b0;
      chg_q   <= 1'b0;
    end else begin
      chg_q <= 1'b0;
      if (obs_vld_i) begin
        agr_q  <= agr_d;
        last_q <= obs_i;
        if (agr_d == AGR_MAX) begin
          rate_q  <= obs_i.frac;
          drift_q <= obs_i.drift;
          chg_q   <= (obs_i.frac != rate_q);
        end
      end
    end
  end

  assign rate_frac_o = rate_q;
  assign drift_o     = drift_q;
  assign rate_chg_o  = chg_q;

  a_r6_pulse_one_cycle: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    chg_q |=> !chg_q);
  a_r6_flip_needs_pulse: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    !$stable(rate_q) |-> chg_q);
  a_r6_pulse_needs_flip: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    chg_q |-> !$stable(rate_q));
  a_r5_commit_after_run: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (!$stable(rate_q) || !$stable(drift_q)) |-> (agr_q == AGR_MAX));
  a_r5_agree_bound: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    agr_q <= AGR_MAX);
endmodule

// File: rtl/sdi_rate_detect.sv
`timescale 1ns/1ps
module sdi_rate_detect
  import srd_pkg::*;
#(
  parameter int WIN_LOG2 = 16,
  parameter int CNT_W    = 20,
  parameter int VALID_N  = 4,
  parameter int SYNC_N   = 2
) (
  input  logic             ref_clk_i,
  input  logic             rec_clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] nominal_cnt_i,
  input  logic [CNT_W-1:0] drift_thr_i,
  output logic             rate_frac_o,
  output logic             rate_chg_o,
  output logic             drift_o
);
  logic             req_tgl, ack_tgl, meas_vld, obs_vld;
  logic [CNT_W-1:0] hold_cnt, meas_cnt;
  srd_obs_t         obs;

  srd_rec_count #(.CNT_W(CNT_W), .SYNC_N(SYNC_N)) u_rec (
    .rec_clk_i (rec_clk_i),
    .rst_ni    (rst_ni),
    .req_tgl_i (req_tgl),
    .hold_o    (hold_cnt),
    .ack_tgl_o (ack_tgl)
  );

  srd_window #(.WIN_LOG2(WIN_LOG2), .CNT_W(CNT_W), .SYNC_N(SYNC_N)) u_win (
    .ref_clk_i  (ref_clk_i),
    .rst_ni     (rst_ni),
    .hold_i     (hold_cnt),
    .ack_tgl_i  (ack_tgl),
    .req_tgl_o  (req_tgl),
    .meas_vld_o (meas_vld),
    .meas_cnt_o (meas_cnt)
  );

  srd_classify #(.CNT_W(CNT_W)) u_cls (
    .ref_clk_i  (ref_clk_i),
    .rst_ni     (rst_ni),
    .meas_vld_i (meas_vld),
    .meas_cnt_i (meas_cnt),
    .nominal_i  (nominal_cnt_i),
    .thr_i      (drift_thr_i),
    .obs_vld_o  (obs_vld),
    .obs_o      (obs)
  );

  srd_validate #(.VALID_N(VALID_N)) u_val (
    .ref_clk_i   (ref_clk_i),
    .rst_ni      (rst_ni),
    .obs_vld_i   (obs_vld),
    .obs_i       (obs),
    .rate_frac_o (rate_frac_o),
    .drift_o     (drift_o),
    .rate_chg_o  (rate_chg_o)
  );
endmodule

// File: tb/sdi_rate_detect_test.sv
`timescale 1ns/1ps
module sdi_rate_detect_test;
  localparam int WIN_LOG2 = 11;
  localparam int CNT_W    = 16;
  localparam int VALID_N  = 3;
  localparam int WIN_CYC  = 1 << WIN_LOG2;

  typedef struct { logic frac; logic drift; } exp_t;

  logic ref_clk = 1'b0, rec_clk = 1'b0, rst_n = 1'b0;
  logic [CNT_W-1:0] nominal = 16'd4096; // 2048 ref cycles of 20 ns / 10 ns
  logic [CNT_W-1:0] thr     = 16'd8;
  logic rate_frac, rate_chg, drift;
  realtime rec_half = 5.0;
  int total = 0, bad = 0;
  bit done = 0;
  exp_t exp_q[$];

  sdi_rate_detect #(.WIN_LOG2(WIN_LOG2), .CNT_W(CNT_W), .VALID_N(VALID_N)) uut (
    .ref_clk_i(ref_clk), .rec_clk_i(rec_clk), .rst_ni(rst_n),
    .nominal_cnt_i(nominal), .drift_thr_i(thr),
    .rate_frac_o(rate_frac), .rate_chg_o(rate_chg), .drift_o(drift));

  always #10 ref_clk = ~ref_clk;
  always begin #(rec_half) rec_clk = ~rec_clk; end

  task automatic chk(input string tag, input logic act, input logic expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, expv, $time);
    end
  endtask

  // driver: set recovered period, push expected strobe outcome
  task automatic drive(input realtime half, input bit flip, input logic f, input logic d);
    exp_t e;
    if (flip) begin e.frac = f; e.drift = d; exp_q.push_back(e); end
    rec_half = half;
  endtask

  task automatic wait_win(input int n);
    repeat (n * WIN_CYC) @(posedge ref_clk);
    @(negedge ref_clk);
  endtask

  // monitor: every strobe must match the head of the queue
  always @(negedge ref_clk) begin
    if (rst_n && rate_chg && !done) begin
      exp_t e;
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R6 unexpected strobe act=1 exp=0 rate=%0b drift=%0b", rate_frac, drift);
      end else begin
        e = exp_q.pop_front();
        if (rate_frac !== e.frac || drift !== e.drift) begin
          bad++;
          $display("FAIL R6 strobe state act=%0b%0b exp=%0b%0b", rate_frac, drift, e.frac, e.drift);
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge ref_clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge ref_clk);
    chk("R1 reset rate", rate_frac, 1'b0);
    chk("R1 reset drift", drift, 1'b0);
    chk("R1 reset strobe", rate_chg, 1'b0);
    rst_n = 1'b1;
    wait_win(2);
    chk("R1 before first decision rate", rate_frac, 1'b0);
    chk("R1 before first decision drift", drift, 1'b0);
    wait_win(4);
    chk("R3 R2 R7 integer rate", rate_frac, 1'b0);
    chk("R4 integer no drift", drift, 1'b0);

    drive(5.005, 1, 1'b1, 1'b0);            // 1000/1001
    wait_win(2);
    chk("R5 short run holds rate", rate_frac, 1'b0);
    wait_win(5);
    chk("R3 fractional rate", rate_frac, 1'b1);
    chk("R4 fractional no drift", drift, 1'b0);

    drive(5.025, 0, 1'b0, 1'b0);            // slow: fractional class, drift
    wait_win(7);
    chk("R8 drift keeps rate", rate_frac, 1'b1);
    chk("R4 R8 drift on fractional", drift, 1'b1);

    drive(4.985, 1, 1'b0, 1'b1);            // fast: integer class, drift
    wait_win(7);
    chk("R3 fast integer rate", rate_frac, 1'b0);
    chk("R4 drift on integer", drift, 1'b1);

    drive(5.0, 0, 1'b0, 1'b0);
    wait_win(7);
    chk("R8 drift clears", drift, 1'b0);
    chk("R8 rate unchanged", rate_frac, 1'b0);

    drive(5.005, 0, 1'b0, 1'b0);            // 1.5-window excursion
    repeat (WIN_CYC + WIN_CYC/2) @(posedge ref_clk);
    drive(5.0, 0, 1'b0, 1'b0);
    wait_win(6);
    chk("R5 excursion ignored rate", rate_frac, 1'b0);
    chk("R5 excursion ignored drift", drift, 1'b0);

    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R6 missing strobes act=%0d exp=0", exp_q.size());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule